// File: doc/BRIEF.md
# Loop-Capturing Instruction Prefetch Buffer Controller

This block steers a small circular instruction buffer that sits between the fetch unit and the decoder. The buffer holds a run of consecutive instruction words. A look-back pointer marks the oldest word still held, and a look-ahead pointer marks the next word to be requested from memory. Prefetch runs ahead of the word being executed by a bounded distance, and the oldest word is dropped when the buffer would grow past its capacity.

For every taken branch the controller decides what happens to the buffer. A short-form branch whose target lies between the look-back pointer and two words past the look-ahead pointer is a hit: the buffer is kept, so a loop that fits inside the buffer runs without refetching. A short-form delayed branch that misses forward while the mode flag is set also keeps the buffer, and decode waits for prefetch to reach the target. Every other taken branch flushes the buffer and restarts prefetch at the target. A single mode bit decides between waiting and flushing in that case. Branch kinds and direct set and clear inputs update the mode bit.

Decode is stalled whenever the word being executed has not yet been loaded. The fetch address is the look-ahead pointer. It carries the target's halfword offset only for the first request after a flush.

Top module: `loop_fetch_buf`

## Requirements
- R1: After synchronous reset both pointers and the execute word are 0. `fetch_addr` is 0, `fetch_req` is 1, `decode_stall` is 1 and `mode_flag` is 0.
- R2: A taken short-form branch of kind plain (0) or delayed (1), not in a delay slot, whose target word is at or below the execute word is kept when the target word is not below the look-back pointer. Kept means both pointers are unchanged. Below the look-back pointer it flushes.
- R3: The same branch with a target word above the execute word is kept when the target word is no more than look-ahead + 2. At look-ahead + 3 or beyond it flushes, unless R6 applies.
- R4: A taken branch that is long-form (`br_short`=0), sits in a delay slot (`br_in_slot`=1), or is a return (kind 2) always flushes, even when its target lies inside the window.
- R5: A flush sets both pointers and the execute word to the target word. The next `fetch_addr` is the target with bit 0 cleared and bit 1 kept. After the first accepted word it is word aligned. `decode_stall` stays 1 until the target word is accepted.
- R6: A short-form delayed branch outside a delay slot whose forward target misses keeps both pointers when `mode_flag` is 1. Decode stalls until prefetch has loaded the target word. With `mode_flag` 0 the same branch flushes.
- R7: `decode_stall` is 1 exactly when the execute word has not been loaded. While it is 1, `exec_step` does not advance the execute word.
- R8: Each cycle with `fetch_req`=1 and `mem_ready`=1 loads one word and advances the look-ahead pointer. `fetch_req` is 0 once look-ahead is 8 or more words past the execute word.
- R9: The buffer holds at most 32 words. Loading a word that would make it hold 33 advances the look-back pointer by one.
- R10: When `br_taken`=1, kind plain clears `mode_flag` and kind delayed leaves it unchanged. Kind return loads it from bit 4 of `saved_status`. Kind frame (3) clears it and moves no pointer.
- R11: With no `br_taken` in the cycle, `mode_clr` clears `mode_flag` and otherwise `mode_set` sets it. A `br_taken` in the same cycle takes precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_taken | input | 1 | A branch or frame operation takes effect this cycle |
| br_kind | input | 2 | 0 plain, 1 delayed, 2 return, 3 frame |
| br_target | input | 32 | Target byte address |
| br_short | input | 1 | Branch is the one-halfword form |
| br_in_slot | input | 1 | Branch sits in a delay slot |
| saved_status | input | 32 | Saved status word; bit 4 is restored into the mode flag on return |
| mode_set | input | 1 | Set the mode flag |
| mode_clr | input | 1 | Clear the mode flag |
| exec_step | input | 1 | Execution moves to the next sequential word |
| mem_ready | input | 1 | Memory accepts the current fetch request and delivers its word |
| fetch_req | output | 1 | Prefetch request valid |
| fetch_addr | output | 32 | Prefetch byte address |
| decode_stall | output | 1 | Decode must wait for the execute word |
| mode_flag | output | 1 | Cache mode flag |

## Verification
Every output is driven from registers alone. Each result is therefore due exactly one clock edge after the edge that samples its stimulus: a branch decision, a loaded word, a stall release or a mode change. The bench drives inputs at the falling edge, lets one rising edge pass, and samples at the next falling edge, which is exactly that slot. A reference model in the bench takes one step per rising edge from the same inputs. Directed sequences place targets exactly on the window edges (look-back, look-ahead + 2, look-ahead + 3, 32-word capacity) with `mem_ready` held low, so a kept buffer shows up as an unchanged `fetch_addr`.

// File: rtl/loop_fetch_pkg.sv
// Shared types for the loop-capturing prefetch buffer controller.
// Assumes a two-bit branch kind code supplied by the decoder.
package loop_fetch_pkg;

    typedef enum logic [1:0] {
        BK_PLAIN   = 2'd0,
        BK_DELAYED = 2'd1,
        BK_RETURN  = 2'd2,
        BK_FRAME   = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_KEEP  = 2'd1,
        ACT_FLUSH = 2'd2
    } br_act_e;

endpackage

// File: rtl/lfb_window_chk.sv
// Classifies a taken branch as keep, flush or no-op from the pointer window.
// Assumes word pointers, look-back <= execute, and unsigned compares without wrap.
module lfb_window_chk
    import loop_fetch_pkg::*;
#(
    parameter int PW     = 30,
    parameter int MARGIN = 2
) (
    input  logic          br_valid,
    input  br_kind_e      kind,
    input  logic          short_form,
    input  logic          in_slot,
    input  logic          mode,
    input  logic [PW-1:0] lb,
    input  logic [PW-1:0] la,
    input  logic [PW-1:0] ex,
    input  logic [PW-1:0] tw,
    output br_act_e       act
);
    localparam logic [PW-1:0] MARGIN_W = PW'(MARGIN);

    logic eligible;
    logic backward;
    logic hit;
    logic wait_miss;

    // Window test and action selection for the current branch.
    always_comb begin
        eligible  = short_form && !in_slot &&
                    ((kind == BK_PLAIN) || (kind == BK_DELAYED));
        backward  = (tw <= ex);
        hit       = eligible && (backward ? (tw >= lb) : (tw <= la + MARGIN_W));
        wait_miss = eligible && !backward && !hit &&
                    (kind == BK_DELAYED) && mode;
        if (!br_valid || kind == BK_FRAME) begin
            act = ACT_NONE;
        end else if (hit || wait_miss) begin
            act = ACT_KEEP;
        end else begin
            act = ACT_FLUSH;
        end
    end

endmodule

// File: rtl/lfb_ptr_ctrl.sv
// Holds look-back, look-ahead and execute word pointers and drives prefetch.
// Assumes one word per accepted request and that a flush outranks a load.
module lfb_ptr_ctrl
    import loop_fetch_pkg::*;
#(
    parameter int PW       = 30,
    parameter int AHEAD    = 8,
    parameter int CAPACITY = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  br_act_e       act,
    input  logic [PW-1:0] tw,
    input  logic          t_hw,
    input  logic          exec_step,
    input  logic          mem_ready,
    output logic [PW-1:0] lb,
    output logic [PW-1:0] la,
    output logic [PW-1:0] ex,
    output logic          hw_off,
    output logic          fetch_req,
    output logic          decode_stall
);
    localparam logic [PW-1:0] ONE_W   = PW'(1);
    localparam logic [PW-1:0] AHEAD_W = PW'(AHEAD);
    localparam logic [PW-1:0] CAP_W   = PW'(CAPACITY);

    logic [PW-1:0] lb_q, la_q, ex_q;
    logic          hw_q;
    logic [PW-1:0] la_inc;
    logic          accept;

    // Request, stall and load-acceptance decode from the current pointers.
    always_comb begin
        decode_stall = !(ex_q < la_q);
        fetch_req    = (la_q < ex_q) || ((la_q - ex_q) < AHEAD_W);
        accept       = fetch_req && mem_ready;
        la_inc       = la_q + ONE_W;
    end

    // Pointer update: flush, word load, capacity trim and execute advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_q <= '0;
            la_q <= '0;
            ex_q <= '0;
            hw_q <= 1'b0;
        end else if (act == ACT_FLUSH) begin
            lb_q <= tw;
            la_q <= tw;
            ex_q <= tw;
            hw_q <= t_hw;
        end else begin
            if (accept) begin
                la_q <= la_inc;
                hw_q <= 1'b0;
                if ((la_inc - lb_q) > CAP_W) begin
                    lb_q <= lb_q + ONE_W;
                end
            end
            if (act == ACT_KEEP) begin
                ex_q <= tw;
            end else if (exec_step && !decode_stall) begin
                ex_q <= ex_q + ONE_W;
            end
        end
    end

    assign lb     = lb_q;
    assign la     = la_q;
    assign ex     = ex_q;
    assign hw_off = hw_q;

endmodule

// File: rtl/lfb_mode_reg.sv
// Cache mode flag: updated by branch kind, else by direct set/clear.
// Assumes the saved status bit is already selected by the caller.
module lfb_mode_reg
    import loop_fetch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     br_valid,
    input  br_kind_e kind,
    input  logic     saved_bit,
    input  logic     set_i,
    input  logic     clr_i,
    output logic     mode
);
    logic mode_q;

    // Flag update with branch events ahead of direct writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (br_valid) begin
            case (kind)
                BK_PLAIN:   mode_q <= 1'b0;
                BK_DELAYED: mode_q <= mode_q;
                BK_RETURN:  mode_q <= saved_bit;
                default:    mode_q <= 1'b0;
            endcase
        end else if (clr_i) begin
            mode_q <= 1'b0;
        end else if (set_i) begin
            mode_q <= 1'b1;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/loop_fetch_buf.sv
// Top of the loop-capturing prefetch buffer controller.
// Assumes byte addresses, 4-byte words and 2-byte instruction halfwords.
module loop_fetch_buf
    import loop_fetch_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STATUS_W = 32,
    parameter int MODE_BIT = 4,
    parameter int AHEAD    = 8,
    parameter int CAPACITY = 32,
    parameter int MARGIN   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                br_taken,
    input  logic [1:0]          br_kind,
    input  logic [ADDR_W-1:0]   br_target,
    input  logic                br_short,
    input  logic                br_in_slot,
    input  logic [STATUS_W-1:0] saved_status,
    input  logic                mode_set,
    input  logic                mode_clr,
    input  logic                exec_step,
    input  logic                mem_ready,
    output logic                fetch_req,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic                decode_stall,
    output logic                mode_flag
);
    localparam int PW = ADDR_W - 2;

    br_kind_e      kind_w;
    br_act_e       act_w;
    logic [PW-1:0] lb_w, la_w, ex_w;
    logic          hw_w;
    logic          unused_bits;

    assign kind_w      = br_kind_e'(br_kind);
    assign unused_bits = ^{br_target[0], saved_status};

    lfb_window_chk #(.PW(PW), .MARGIN(MARGIN)) win_i (
        .br_valid   (br_taken),
        .kind       (kind_w),
        .short_form (br_short),
        .in_slot    (br_in_slot),
        .mode       (mode_flag),
        .lb         (lb_w),
        .la         (la_w),
        .ex         (ex_w),
        .tw         (br_target[ADDR_W-1:2]),
        .act        (act_w)
    );

    lfb_ptr_ctrl #(.PW(PW), .AHEAD(AHEAD), .CAPACITY(CAPACITY)) ptr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .act          (act_w),
        .tw           (br_target[ADDR_W-1:2]),
        .t_hw         (br_target[1]),
        .exec_step    (exec_step),
        .mem_ready    (mem_ready),
        .lb           (lb_w),
        .la           (la_w),
        .ex           (ex_w),
        .hw_off       (hw_w),
        .fetch_req    (fetch_req),
        .decode_stall (decode_stall)
    );

    lfb_mode_reg mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_valid  (br_taken),
        .kind      (kind_w),
        .saved_bit (saved_status[MODE_BIT]),
        .set_i     (mode_set),
        .clr_i     (mode_clr),
        .mode      (mode_flag)
    );

    assign fetch_addr = {la_w, hw_w, 1'b0};

endmodule

// File: rtl/lfb_checker.sv
// Assertion checker for loop_fetch_buf, attached by bind below.
// Assumes it observes the pointer and action nets of the top module.
module lfb_checker #(
    parameter int ADDR_W   = 32,
    parameter int STATUS_W = 32,
    parameter int MODE_BIT = 4,
    parameter int PW       = 30,
    parameter int AHEAD    = 8,
    parameter int CAPACITY = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                br_taken,
    input logic [1:0]          br_kind,
    input logic [ADDR_W-1:0]   br_target,
    input logic [STATUS_W-1:0] saved_status,
    input logic                mem_ready,
    input logic [1:0]          act,
    input logic [PW-1:0]       lb,
    input logic [PW-1:0]       la,
    input logic [PW-1:0]       ex,
    input logic [ADDR_W-1:0]   fetch_addr,
    input logic                decode_stall,
    input logic                mode_flag
);
    localparam logic [PW-1:0] AHEAD_W = PW'(AHEAD);
    localparam logic [PW-1:0] CAP_W   = PW'(CAPACITY);

    assert_keep_ptrs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd1 && !mem_ready) |=> (lb == $past(lb) && la == $past(la)));

    assert_flush_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd2) |=> (fetch_addr[ADDR_W-1:1] == $past(br_target[ADDR_W-1:1]) && decode_stall));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_stall && act == 2'd0) |=> (ex == $past(ex)));

    assert_ahead_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((la >= ex) && ((la - ex) >= AHEAD_W) && act != 2'd2) |=> (la == $past(la)));

    assert_capacity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lb <= la) && ((la - lb) <= CAP_W));

    assert_delayed_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && br_kind == 2'd1) |=> (mode_flag == $past(mode_flag)));

    assert_return_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && br_kind == 2'd2) |=> (mode_flag == $past(saved_status[MODE_BIT])));

    assert_frame_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && br_kind == 2'd3) |=> !mode_flag);

endmodule

bind loop_fetch_buf lfb_checker #(
    .ADDR_W   (ADDR_W),
    .STATUS_W (STATUS_W),
    .MODE_BIT (MODE_BIT),
    .PW       (PW),
    .AHEAD    (AHEAD),
    .CAPACITY (CAPACITY)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_taken     (br_taken),
    .br_kind      (br_kind),
    .br_target    (br_target),
    .saved_status (saved_status),
    .mem_ready    (mem_ready),
    .act          (act_w),
    .lb           (lb_w),
    .la           (la_w),
    .ex           (ex_w),
    .fetch_addr   (fetch_addr),
    .decode_stall (decode_stall),
    .mode_flag    (mode_flag)
);

// File: tb/loop_fetch_buf_tb_top.sv
// Self-checking bench: directed window corners plus seeded random stimulus,
// compared each cycle with a reference model built from the requirements.
module loop_fetch_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_taken = 1'b0;
    logic [1:0]  br_kind = 2'd0;
    logic [31:0] br_target = '0;
    logic        br_short = 1'b0;
    logic        br_in_slot = 1'b0;
    logic [31:0] saved_status = '0;
    logic        mode_set = 1'b0;
    logic        mode_clr = 1'b0;
    logic        exec_step = 1'b0;
    logic        mem_ready = 1'b0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        decode_stall;
    logic        mode_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [29:0] m_lb, m_la, m_ex;
    logic        m_hw, m_mode;

    always #10 clk = ~clk;

    loop_fetch_buf dut_i (
        .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_kind(br_kind),
        .br_target(br_target), .br_short(br_short), .br_in_slot(br_in_slot),
        .saved_status(saved_status), .mode_set(mode_set), .mode_clr(mode_clr),
        .exec_step(exec_step), .mem_ready(mem_ready), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .decode_stall(decode_stall), .mode_flag(mode_flag)
    );

    function automatic logic exp_stall();
        return !(m_ex < m_la);
    endfunction

    function automatic logic exp_req();
        return (m_la < m_ex) || ((m_la - m_ex) < 30'd8);
    endfunction

    function automatic logic [31:0] exp_addr();
        return {m_la, m_hw, 1'b0};
    endfunction

    // 0 none, 1 keep, 2 flush
    function automatic int classify(logic [1:0] k, logic s, logic slot, logic [29:0] tw);
        logic elig, back, hit;
        elig = s && !slot && (k <= 2'd1);
        back = (tw <= m_ex);
        hit  = elig && (back ? (tw >= m_lb) : (tw <= m_la + 30'd2));
        if (k == 2'd3) return 0;
        if (hit) return 1;
        if (elig && !back && k == 2'd1 && m_mode) return 1;
        return 2;
    endfunction

    task automatic model_step();
        logic [29:0] tw;
        logic stl, acc;
        int act;
        if (!rst_n) begin
            m_lb = '0; m_la = '0; m_ex = '0; m_hw = 1'b0; m_mode = 1'b0;
            return;
        end
        tw  = br_target[31:2];
        stl = exp_stall();
        acc = exp_req() && mem_ready;
        act = br_taken ? classify(br_kind, br_short, br_in_slot, tw) : 0;
        if (act == 2) begin
            m_lb = tw; m_la = tw; m_ex = tw; m_hw = br_target[1];
        end else begin
            if (acc) begin
                m_la = m_la + 30'd1;
                m_hw = 1'b0;
                if ((m_la - m_lb) > 30'd32) m_lb = m_lb + 30'd1;
            end
            if (act == 1) m_ex = tw;
            else if (exec_step && !stl) m_ex = m_ex + 30'd1;
        end
        if (br_taken) begin
            case (br_kind)
                2'd0: m_mode = 1'b0;
                2'd1: m_mode = m_mode;
                2'd2: m_mode = saved_status[4];
                default: m_mode = 1'b0;
            endcase
        end else if (mode_clr) m_mode = 1'b0;
        else if (mode_set) m_mode = 1'b1;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (fetch_addr !== exp_addr() || fetch_req !== exp_req() ||
            decode_stall !== exp_stall() || mode_flag !== m_mode) begin
            errors++;
            $display("FAIL %s: addr=%h/%h req=%b/%b stall=%b/%b mode=%b/%b (actual/expected)",
                     tag, fetch_addr, exp_addr(), fetch_req, exp_req(),
                     decode_stall, exp_stall(), mode_flag, m_mode);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic branch(input logic [1:0] k, input logic [31:0] tgt,
                          input logic s, input logic slot, input string tag);
        br_taken = 1'b1; br_kind = k; br_target = tgt; br_short = s; br_in_slot = slot;
        tick(tag);
        br_taken = 1'b0; br_short = 1'b0; br_in_slot = 1'b0;
    endtask

    task automatic fill(input int n, input string tag);
        mem_ready = 1'b1;
        repeat (n) tick(tag);
        mem_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] keep_addr;
        logic [31:0] tgt;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) tick("R1");
        rst_n = 1'b1;
        chk("R1 fetch_addr", fetch_addr, 32'h0);
        chk("R1 fetch_req", {31'd0, fetch_req}, 32'd1);
        chk("R1 decode_stall", {31'd0, decode_stall}, 32'd1);
        chk("R1 mode_flag", {31'd0, mode_flag}, 32'd0);

        // R5: flush keeps halfword bit on first request
        branch(2'd0, 32'h102, 1'b0, 1'b0, "R5");
        chk("R5 first addr", fetch_addr, 32'h102);
        chk("R5 stall", {31'd0, decode_stall}, 32'd1);
        fill(1, "R5");
        chk("R5 next addr", fetch_addr, 32'h104);
        chk("R5 stall released", {31'd0, decode_stall}, 32'd0);

        // R7: exec_step ignored while stalled
        branch(2'd0, 32'h200, 1'b0, 1'b0, "R7");
        exec_step = 1'b1;
        tick("R7"); tick("R7");
        mem_ready = 1'b1; tick("R7");
        exec_step = 1'b0; mem_ready = 1'b0;
        chk("R7 stall after load", {31'd0, decode_stall}, 32'd0);

        // R8: prefetch limit of 8 words
        branch(2'd0, 32'h100, 1'b0, 1'b0, "R5");
        fill(12, "R8");
        chk("R8 fetch_req", {31'd0, fetch_req}, 32'd0);
        chk("R8 fetch_addr", fetch_addr, 32'h120);

        // R3: forward target at look-ahead + 2 is kept
        branch(2'd0, 32'h128, 1'b1, 1'b0, "R3");
        chk("R3 kept addr", fetch_addr, 32'h120);
        chk("R3 stall", {31'd0, decode_stall}, 32'd1);
        fill(3, "R3");
        chk("R3 stall released", {31'd0, decode_stall}, 32'd0);

        // R2: backward to look-back kept, below it flushes
        branch(2'd0, 32'h100, 1'b1, 1'b0, "R2");
        chk("R2 kept addr", fetch_addr, 32'h12C);
        chk("R2 no stall", {31'd0, decode_stall}, 32'd0);
        branch(2'd0, 32'hFC, 1'b1, 1'b0, "R2");
        chk("R2 below lb flush", fetch_addr, 32'hFC);

        // R3: look-ahead + 3 flushes
        fill(4, "R3");
        branch(2'd0, 32'h118, 1'b1, 1'b0, "R3");
        chk("R3 margin+1 flush", fetch_addr, 32'h118);

        // R11 and R6: stall on forward miss with mode set
        mode_set = 1'b1; tick("R11"); mode_set = 1'b0;
        chk("R11 set", {31'd0, mode_flag}, 32'd1);
        fill(2, "R6");
        branch(2'd1, 32'h130, 1'b1, 1'b0, "R6");
        chk("R6 kept addr", fetch_addr, 32'h120);
        chk("R6 stall", {31'd0, decode_stall}, 32'd1);
        chk("R6 mode kept", {31'd0, mode_flag}, 32'd1);
        fill(4, "R6");
        chk("R6 still stalled", {31'd0, decode_stall}, 32'd1);
        fill(1, "R6");
        chk("R6 stall released", {31'd0, decode_stall}, 32'd0);
        mode_clr = 1'b1; tick("R11"); mode_clr = 1'b0;
        chk("R11 clear", {31'd0, mode_flag}, 32'd0);
        branch(2'd1, 32'h140, 1'b1, 1'b0, "R6");
        chk("R6 mode0 flush", fetch_addr, 32'h140);

        // R4: long form, delay slot and return flush inside the window
        fill(2, "R4");
        branch(2'd0, 32'h144, 1'b0, 1'b0, "R4");
        chk("R4 long flush", fetch_addr, 32'h144);
        fill(2, "R4");
        branch(2'd1, 32'h148, 1'b1, 1'b1, "R4");
        chk("R4 slot flush", fetch_addr, 32'h148);
        fill(2, "R4");
        saved_status = 32'h0000_0010;
        branch(2'd2, 32'h14C, 1'b1, 1'b0, "R4");
        chk("R4 return flush", fetch_addr, 32'h14C);
        chk("R10 return restores", {31'd0, mode_flag}, 32'd1);
        saved_status = '0;

        // R10: frame clears mode, pointers untouched
        fill(1, "R10");
        branch(2'd3, 32'h0, 1'b0, 1'b0, "R10");
        chk("R10 frame clears", {31'd0, mode_flag}, 32'd0);
        chk("R10 frame addr", fetch_addr, 32'h150);

        // R11: branch event beats clear; R10: delayed keeps, plain clears
        mode_set = 1'b1; tick("R11"); mode_set = 1'b0;
        mode_clr = 1'b1;
        branch(2'd1, 32'h150, 1'b1, 1'b0, "R11");
        mode_clr = 1'b0;
        chk("R11 event wins", {31'd0, mode_flag}, 32'd1);
        branch(2'd0, 32'h150, 1'b1, 1'b0, "R10");
        chk("R10 plain clears", {31'd0, mode_flag}, 32'd0);

        // R9: 32-word capacity edge
        branch(2'd0, 32'h800, 1'b0, 1'b0, "R9");
        exec_step = 1'b1; mem_ready = 1'b1;
        repeat (60) tick("R9");
        exec_step = 1'b0; mem_ready = 1'b0;
        tick("R9");
        keep_addr = fetch_addr;
        tgt = {m_lb, 2'b00};
        branch(2'd0, tgt, 1'b1, 1'b0, "R9");
        chk("R9 oldest word kept", fetch_addr, keep_addr);
        tgt = {m_lb - 30'd1, 2'b00};
        branch(2'd0, tgt, 1'b1, 1'b0, "R9");
        chk("R9 evicted word flush", fetch_addr, tgt);

        // Random mix against the model
        branch(2'd0, 32'h4000, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 4000; i++) begin
            int off;
            logic [29:0] tw;
            off = int'($urandom_range(52)) - 40;
            tw  = m_ex + 30'(off);
            br_taken     = ($urandom_range(5) == 0);
            br_kind      = 2'($urandom_range(3));
            br_target    = {tw, 1'($urandom_range(1)), 1'b0};
            br_short     = ($urandom_range(3) != 0);
            br_in_slot   = ($urandom_range(7) == 0);
            saved_status = $urandom;
            mode_set     = ($urandom_range(15) == 0);
            mode_clr     = ($urandom_range(15) == 0);
            exec_step    = ($urandom_range(1) == 1);
            mem_ready    = ($urandom_range(3) != 0);
            tick("random R2 R3 R6 R7 R8 R9 R10");
        end
        br_taken = 1'b0; mode_set = 1'b0; mode_clr = 1'b0;
        exec_step = 1'b0; mem_ready = 1'b0;
        tick("random tail");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule